// File: doc/BRIEF.md
# Routed GPIO Pin Interrupt Unit

This block turns a set of 16-bit general-purpose I/O ports into one interrupt request line with 32 individually controlled sources. The 32 lines form four groups of eight. A selection register holds one byte per group, and that byte names the port the group draws from. Even-numbered groups take the lower eight pins of the named port and odd-numbered groups take the upper eight, so any half-port can reach any group of the matching parity.

Every routed pin is synchronised, optionally inverted, and then sensed either on its level or on its edge. A detected event sets a pending bit. The pending bits that are enabled drive the single interrupt output. Software works through a small word-addressed register bus. The enable, trigger-mode and polarity controls each have a set address and a clear address, so one line can be changed without a read-modify-write. Two read-only views are also provided: the conditioned pin levels, and a capture register that records events whether or not the line is enabled.

Top module: `pinirq_unit`

## Requirements
- R1: After reset the enable, trigger-mode, polarity, pending and capture registers read 0, the selection register reads the parameter ASSIGN_RST (default 32'h0101_0000), and irq_o is low.
- R2: The register word addresses are: 0 selection, 1 enable-set, 2 enable-clear, 3 pending, 4 trigger-set, 5 trigger-clear, 6 polarity-set, 7 polarity-clear, 8 conditioned level, 9 capture. The set and clear addresses of a control both read back that control's current value.
- R3: Writing to enable-set sets the enable bits that are 1 in the data. Writing to enable-clear clears them. Bits written as 0 keep their value. Trigger and polarity follow the same rule.
- R4: Byte g of the selection register (bits 8g+7..8g) picks port number p for lines 8g..8g+7. Even g takes pins 7..0 of port p and odd g takes pins 15..8. A byte value of N_PORTS or more feeds constant 0 before polarity is applied.
- R5: The conditioned-level view shows the routed pin XOR its polarity bit, two rising clock edges after the pin changes.
- R6: For a line with trigger bit 1 (edge mode), a rising edge of the conditioned level sets the pending bit on the third clock edge after the pin change. The bit stays set until a 1 is written to it at the pending address. When an event and an acknowledge arrive on the same edge, the event wins.
- R7: For a line with trigger bit 0 (level mode), the pending bit equals the conditioned level one edge later, and writing a 1 to it has no effect while the level is active.
- R8: Polarity bit 1 makes a line active low in level mode and sensitive to falling edges in edge mode.
- R9: irq_o is high exactly when some bit is 1 in both pending and enable. It follows the registers in the same cycle.
- R10: The capture register sets a bit for every detected event, whether the line is enabled or not. Writing a 1 at the capture address clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | N_PORTS*16 | Asynchronous port pins, port p in bits 16p+15..16p |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin change reaches the conditioned-level view after two clock edges and the pending bit and irq_o after three. Register writes take effect on the edge that carries them, and read data is combinational. The bench drives inputs and samples outputs just after falling edges. For the pin-to-view and pin-to-pending delays it counts the edges and reads at exactly the second and the third edge, which confirms that neither result appears early. The event-versus-acknowledge check puts its acknowledge write on the same edge where the event lands.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int LINES   = 32;
  localparam int GROUP_W = 8;
  localparam int GROUPS  = LINES / GROUP_W;
  localparam int PORT_W  = 16;
  localparam int ADDR_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_ASSIGN   = 4'd0,
    RA_EN_SET   = 4'd1,
    RA_EN_CLR   = 4'd2,
    RA_PEND     = 4'd3,
    RA_TRIG_SET = 4'd4,
    RA_TRIG_CLR = 4'd5,
    RA_POL_SET  = 4'd6,
    RA_POL_CLR  = 4'd7,
    RA_LEVEL    = 4'd8,
    RA_CAPT     = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/pinirq_route.sv
module pinirq_route
  import pinirq_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic [N_PORTS*PORT_W-1:0] pins_s,
  input  logic [LINES-1:0]          sel,
  input  logic [LINES-1:0]          pol,
  output logic [LINES-1:0]          cond
);
  logic [LINES-1:0] raw;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int OFS = (g % 2) * GROUP_W;
    logic [GROUP_W-1:0] bsel;
    logic [GROUP_W-1:0] grp;

    assign bsel = sel[g*GROUP_W +: GROUP_W];

    always_comb begin
      grp = '0;
      for (int p = 0; p < N_PORTS; p++) begin
        if (bsel == GROUP_W'(p)) grp = pins_s[p*PORT_W+OFS +: GROUP_W];
      end
    end

    assign raw[g*GROUP_W +: GROUP_W] = grp;
  end

  assign cond = raw ^ pol;
endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect
  import pinirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] cond,
  input  logic [LINES-1:0] trig,
  input  logic [LINES-1:0] ack_pend,
  input  logic [LINES-1:0] ack_capt,
  output logic [LINES-1:0] pend_q,
  output logic [LINES-1:0] capt_q
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] evt;
  logic [LINES-1:0] pend_n;
  logic [LINES-1:0] capt_n;

  always_comb begin
    evt    = (trig & cond & ~prev_q) | (~trig & cond);
    pend_n = (trig & (evt | (pend_q & ~ack_pend))) | (~trig & cond);
    capt_n = evt | (capt_q & ~ack_capt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      capt_q <= '0;
    end else begin
      prev_q <= cond;
      pend_q <= pend_n;
      capt_q <= capt_n;
    end
  end
endmodule

// File: rtl/pinirq_unit.sv
module pinirq_unit
  import pinirq_pkg::*;
#(
  parameter int          N_PORTS    = 4,
  parameter logic [31:0] ASSIGN_RST = 32'h0101_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS*PORT_W-1:0] pins_i,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [LINES-1:0]          bus_wdata,
  output logic [LINES-1:0]          bus_rdata,
  output logic                      irq_o
);
  localparam int PIN_W = N_PORTS * PORT_W;

  logic             rst_meta_q, rst_int_n;
  logic [PIN_W-1:0] pins_s;
  logic [LINES-1:0] cond;
  logic [LINES-1:0] mask_q, mask_n;
  logic [LINES-1:0] trig_q, trig_n;
  logic [LINES-1:0] pol_q, pol_n;
  logic [LINES-1:0] sel_q, sel_n;
  logic [LINES-1:0] req_q, capt_q;
  logic [LINES-1:0] ack_pend, ack_capt;
  logic             ctl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  pinirq_sync #(.W(PIN_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_i  (pins_i),
    .q_o  (pins_s)
  );

  pinirq_route #(.N_PORTS(N_PORTS)) u_route (
    .pins_s(pins_s),
    .sel   (sel_q),
    .pol   (pol_q),
    .cond  (cond)
  );

  assign ack_pend = (bus_we && bus_addr == RA_PEND) ? bus_wdata : '0;
  assign ack_capt = (bus_we && bus_addr == RA_CAPT) ? bus_wdata : '0;

  pinirq_detect u_detect (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cond    (cond),
    .trig    (trig_q),
    .ack_pend(ack_pend),
    .ack_capt(ack_capt),
    .pend_q  (req_q),
    .capt_q  (capt_q)
  );

  always_comb begin
    mask_n = mask_q;
    trig_n = trig_q;
    pol_n  = pol_q;
    sel_n  = sel_q;
    ctl_en = 1'b0;
    if (bus_we) begin
      ctl_en = 1'b1;
      case (reg_addr_e'(bus_addr))
        RA_ASSIGN:   sel_n  = bus_wdata;
        RA_EN_SET:   mask_n = mask_q | bus_wdata;
        RA_EN_CLR:   mask_n = mask_q & ~bus_wdata;
        RA_TRIG_SET: trig_n = trig_q | bus_wdata;
        RA_TRIG_CLR: trig_n = trig_q & ~bus_wdata;
        RA_POL_SET:  pol_n  = pol_q | bus_wdata;
        RA_POL_CLR:  pol_n  = pol_q & ~bus_wdata;
        default:     ctl_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q <= '0;
      trig_q <= '0;
      pol_q  <= '0;
      sel_q  <= ASSIGN_RST;
    end else if (ctl_en) begin
      mask_q <= mask_n;
      trig_q <= trig_n;
      pol_q  <= pol_n;
      sel_q  <= sel_n;
    end
  end

  always_comb begin
    case (reg_addr_e'(bus_addr))
      RA_ASSIGN:               bus_rdata = sel_q;
      RA_EN_SET,   RA_EN_CLR:  bus_rdata = mask_q;
      RA_PEND:                 bus_rdata = req_q;
      RA_TRIG_SET, RA_TRIG_CLR: bus_rdata = trig_q;
      RA_POL_SET,  RA_POL_CLR: bus_rdata = pol_q;
      RA_LEVEL:                bus_rdata = cond;
      RA_CAPT:                 bus_rdata = capt_q;
      default:                 bus_rdata = '0;
    endcase
  end

  assign irq_o = |(req_q & mask_q);
endmodule

// File: rtl/pinirq_unit_chk.sv
module pinirq_unit_chk
  import pinirq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LINES-1:0] bus_wdata,
  input logic [LINES-1:0] mask_q,
  input logic [LINES-1:0] trig_q,
  input logic [LINES-1:0] req_q,
  input logic [LINES-1:0] cond,
  input logic             irq_o
);
  logic [LINES-1:0] ack_seen;
  assign ack_seen = (bus_we && bus_addr == RA_PEND) ? bus_wdata : '0;

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RA_EN_SET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R3

  AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RA_EN_CLR) |=> ((mask_q & $past(bus_wdata)) == '0)); // R3

  AST_EDGE_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(req_q) & $past(trig_q) & ~$past(ack_seen)) & ~req_q) == '0)); // R6

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & ~$past(trig_q)) == ($past(cond) & ~$past(trig_q)))); // R7

  AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o); // R9
endmodule

bind pinirq_unit pinirq_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .mask_q   (mask_q),
  .trig_q   (trig_q),
  .req_q    (req_q),
  .cond     (cond),
  .irq_o    (irq_o)
);

// File: tb/pinirq_unit_tb_top.sv
`timescale 1ns/1ps
module pinirq_unit_tb_top;
  localparam int NP = 4;
  localparam int NV = 4;

  localparam logic [3:0] A_ASSIGN = 4'd0, A_EN_SET = 4'd1, A_EN_CLR = 4'd2,
    A_PEND = 4'd3, A_TRIG_SET = 4'd4, A_TRIG_CLR = 4'd5, A_POL_SET = 4'd6,
    A_POL_CLR = 4'd7, A_LEVEL = 4'd8, A_CAPT = 4'd9;

  localparam logic [31:0] V_SEL [NV] = '{32'h0101_0000, 32'h0302_0100,
                                         32'h0000_0303, 32'h0907_0205};
  localparam logic [63:0] V_PIN [NV] = '{64'h0000_0000_BEEF_1234, 64'h1122_3344_5566_7788,
                                         64'h1122_3344_5566_7788, 64'h1122_3344_5566_7788};
  localparam logic [31:0] V_EXP [NV] = '{32'hBEEF_1234, 32'h1144_5588,
                                         32'h7788_1122, 32'h0000_3300};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] pins;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pinirq_unit #(.N_PORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  logic [31:0] v;

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pins = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R1 reset state
    rd(A_ASSIGN, v);   chk("R1 selection", v, 32'h0101_0000);
    rd(A_EN_SET, v);   chk("R1 enable", v, 32'h0);
    rd(A_TRIG_SET, v); chk("R1 trigger", v, 32'h0);
    rd(A_POL_SET, v);  chk("R1 polarity", v, 32'h0);
    rd(A_PEND, v);     chk("R1 pending", v, 32'h0);
    rd(A_CAPT, v);     chk("R1 capture", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R4 routing table, R7 level-mode pending follows
    for (int i = 0; i < NV; i++) begin
      wr(A_ASSIGN, V_SEL[i]);
      pins = V_PIN[i];
      step(3);
      rd(A_LEVEL, v); chk("R4 routed level", v, V_EXP[i]);
      rd(A_PEND, v);  chk("R7 level pending", v, V_EXP[i]);
    end
    pins = '0;
    wr(A_ASSIGN, 32'h0101_0000);
    step(3);
    wr(A_CAPT, 32'hFFFF_FFFF);
    rd(A_CAPT, v); chk("R10 capture cleared", v, 32'h0);

    // R3 set/clear, R2 read-back from both addresses
    wr(A_EN_SET, 32'hF0);
    rd(A_EN_SET, v); chk("R3 enable set", v, 32'hF0);
    wr(A_EN_SET, 32'h0F);
    rd(A_EN_SET, v); chk("R3 enable set keeps zeros", v, 32'hFF);
    wr(A_EN_CLR, 32'h30);
    rd(A_EN_CLR, v); chk("R2 R3 enable clear", v, 32'hCF);
    chk("R9 no pending no irq", {31'b0, irq}, 32'h0);
    wr(A_TRIG_SET, 32'hFFFF_FFFF);
    rd(A_TRIG_CLR, v); chk("R2 trigger via clear addr", v, 32'hFFFF_FFFF);
    wr(A_EN_CLR, 32'hFFFF_FFFF);
    wr(A_EN_SET, 32'h1);

    // R6 edge mode timing and hold
    pins[0] = 1'b1;
    step(2);
    rd(A_LEVEL, v); chk("R5 level after two edges", v, 32'h1);
    rd(A_PEND, v);  chk("R6 pending not early", v, 32'h0);
    step(1);
    rd(A_PEND, v);  chk("R6 pending on third edge", v, 32'h1);
    chk("R9 irq with enabled pending", {31'b0, irq}, 32'h1);
    pins[0] = 1'b0;
    step(4);
    rd(A_PEND, v);  chk("R6 edge pending holds", v, 32'h1);
    wr(A_PEND, 32'h1);
    rd(A_PEND, v);  chk("R6 acknowledge", v, 32'h0);
    chk("R9 irq drops", {31'b0, irq}, 32'h0);
    rd(A_CAPT, v);  chk("R10 capture event", v, 32'h1);

    // R10 capture on disabled line, R9 masking
    pins[1] = 1'b1;
    step(3);
    rd(A_PEND, v);  chk("R6 disabled line pends", v, 32'h2);
    chk("R9 disabled line no irq", {31'b0, irq}, 32'h0);
    rd(A_CAPT, v);  chk("R10 capture while disabled", v, 32'h3);
    wr(A_CAPT, 32'h3);
    rd(A_CAPT, v);  chk("R10 capture W1C", v, 32'h0);
    wr(A_PEND, 32'h2);

    // R8 falling edge with polarity
    pins[2] = 1'b1;
    step(3);
    wr(A_POL_SET, 32'h4);
    wr(A_PEND, 32'h4);
    wr(A_CAPT, 32'hFFFF_FFFF);
    rd(A_PEND, v);  chk("R8 no event on polarity flip", v, 32'h0);
    rd(A_LEVEL, v); chk("R8 inverted level", v, 32'h2);
    pins[2] = 1'b0;
    step(2);
    rd(A_LEVEL, v); chk("R5 R8 level after fall", v, 32'h6);
    step(1);
    rd(A_PEND, v);  chk("R8 falling edge pends", v, 32'h4);

    // R7 level mode ignores acknowledge while active
    wr(A_TRIG_CLR, 32'h8);
    pins[3] = 1'b1;
    step(3);
    rd(A_PEND, v);  chk("R7 level pends", v, 32'hC);
    wr(A_PEND, 32'hC);
    rd(A_PEND, v);  chk("R7 ack ignored while active", v, 32'h8);
    pins[3] = 1'b0;
    step(3);
    rd(A_PEND, v);  chk("R7 follows level low", v, 32'h0);

    // R6 event beats simultaneous acknowledge
    pins[4] = 1'b1;
    step(2);
    wr(A_PEND, 32'h10);
    rd(A_PEND, v);  chk("R6 event wins over ack", v, 32'h10);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule